// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is the slave side of a serial NOR flash on a four-wire SPI bus in mode 0. Chip select is active low. Input data is sampled on the rising edge of SCK and output data changes on the falling edge, one bit per clock, most significant bit first. The block runs on a system clock that is much faster than SCK. It finds SCK edges by comparing SCK with a registered copy of itself, so `cs_n`, `sck` and `mosi` must be synchronous to `clk`. The storage is a 1 KiB byte array. It holds a 256-byte window at the bottom of each of the four 16 MiB address segments: address bits [25:24] choose the window and bits [7:0] choose the byte. All other address bits are ignored. Because of this, the segment offset applied to 3-byte addresses can be seen at the pins.

A command starts with an opcode byte after chip select falls. The command engine is a state machine with these states:

- IDLE waits for the opcode.
- ADDR collects 3 or 4 address bytes.
- DUMMY skips the configured number of padding bytes for a fast read.
- READ streams stored bytes.
- PROG clears bits in stored bytes.
- XWR takes the one byte for the segment register.
- RESP shifts out a one-byte register value and then zeros.
- SINK ignores the rest of the frame.

The transitions are:

- IDLE to ADDR on an address-taking opcode.
- IDLE to RESP on a register read.
- IDLE to XWR on a segment write while write enable is set.
- IDLE to SINK on any other opcode.
- ADDR to DUMMY, READ, PROG or SINK on the last address byte, SINK when the command is refused or is an erase.
- DUMMY to READ on the last padding byte.
- XWR to SINK.
- Every state to IDLE when chip select rises.

An erase runs in the background at one byte per system clock, after the last address byte.

Top module: `sfe_flash_engine`

## Requirements
- R1: After reset, and whenever chip select is high, `miso` is 0. After reset the flag status byte reads 0x80 and the segment register reads 0x00. All array bytes start at 0xFF.
- R2: Read opcode 0x03 takes the address most significant byte first. It then returns the stored bytes starting at that address. The byte offset increments after each byte and wraps from 0xFF to 0x00 inside the same 256-byte window.
- R3: Opcodes 0x13, 0x0C, 0x12, 0x21 and 0xDC always take a 4-byte address. Opcode 0xB7 selects 4-byte mode and 0xE9 leaves it. In 4-byte mode, opcodes 0x03, 0x0B, 0x02, 0x20 and 0xD8 also take 4 bytes; otherwise they take 3.
- R4: Opcode 0x70 returns one flag byte. Bit 7 of that byte is always 1, bit 0 is 1 in 4-byte mode, and the other bits are 0.
- R5: A 3-byte address has (segment register & 3) × 0x1000000 added to it. The array byte used is {address[25:24], address[7:0]}.
- R6: Opcode 0xC8 returns the segment register. Opcode 0xC5 loads it from the next byte, but only if write enable is set; if not, the register keeps its value.
- R7: Fast reads 0x0B and 0x0C skip `fast_dummy` bytes after the address before data starts. With a count of 0, data starts at once.
- R8: Opcode 0x06 sets write enable. Programs 0x02 and 0x12 AND each data byte into the stored byte and advance the offset as a read does. Without write enable, a program changes nothing.
- R9: With write enable set, 0x20 and 0x21 set the aligned 16-byte block that holds the address to 0xFF, and 0xD8 and 0xDC do the same for the aligned 64-byte block. Bytes outside the block are unchanged. Without write enable, an erase does nothing.
- R10: Write enable is cleared when chip select rises at the end of a program, and when an erase finishes.
- R11: Opcode 0x66 arms a reset. If the very next opcode is 0x99, the reset happens: write enable, 4-byte mode, the segment register and the armed flag are all cleared. Any other opcode disarms it.
- R12: When chip select rises in the middle of a command, the command ends and the next frame is decoded from its first byte as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_dummy | input | 4 | Number of padding bytes for fast reads |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
A received byte is acted on at the system clock edge that first sees the eighth rising SCK edge. A response byte is loaded into the output shifter at the first falling SCK edge after that. `miso` then changes one system clock after each falling SCK edge. The bench holds each SCK half period for four system clocks and samples `miso` just before it raises SCK, so every bit it reads has had three spare clocks to settle. An erase needs at most 64 system clocks after its last address byte. The bench waits 100 clocks after deselecting before it reads the block back.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int WIN_AW = 8;
    localparam int SEG_W  = 2;
    localparam int IDX_W  = WIN_AW + SEG_W;

    localparam logic [7:0] OP_RD3   = 8'h03;
    localparam logic [7:0] OP_RD4   = 8'h13;
    localparam logic [7:0] OP_FR3   = 8'h0B;
    localparam logic [7:0] OP_FR4   = 8'h0C;
    localparam logic [7:0] OP_PP3   = 8'h02;
    localparam logic [7:0] OP_PP4   = 8'h12;
    localparam logic [7:0] OP_ES3   = 8'h20;
    localparam logic [7:0] OP_ES4   = 8'h21;
    localparam logic [7:0] OP_EB3   = 8'hD8;
    localparam logic [7:0] OP_EB4   = 8'hDC;
    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_M4ON  = 8'hB7;
    localparam logic [7:0] OP_M4OFF = 8'hE9;
    localparam logic [7:0] OP_FLAG  = 8'h70;
    localparam logic [7:0] OP_XRD   = 8'hC8;
    localparam logic [7:0] OP_XWR   = 8'hC5;
    localparam logic [7:0] OP_ARM   = 8'h66;
    localparam logic [7:0] OP_RST   = 8'h99;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_DUMMY, S_READ, S_PROG, S_XWR, S_RESP, S_SINK
    } eng_state_t;

    typedef enum logic [1:0] {K_READ, K_PROG, K_ERASE} cmd_kind_t;

    function automatic logic op_wide(input logic [7:0] op);
        return (op == OP_RD4) || (op == OP_FR4) || (op == OP_PP4) ||
               (op == OP_ES4) || (op == OP_EB4);
    endfunction

    function automatic logic op_fast(input logic [7:0] op);
        return (op == OP_FR3) || (op == OP_FR4);
    endfunction

    function automatic logic op_big(input logic [7:0] op);
        return (op == OP_EB3) || (op == OP_EB4);
    endfunction

    function automatic cmd_kind_t op_kind(input logic [7:0] op);
        if ((op == OP_PP3) || (op == OP_PP4)) return K_PROG;
        if ((op == OP_ES3) || (op == OP_ES4) || op_big(op)) return K_ERASE;
        return K_READ;
    endfunction

endpackage

// File: rtl/sfe_bit_shifter.sv
module sfe_bit_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       miso
);
    logic       sck_q;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       rise;
    logic       fall;

    assign rise     = !cs_n && sck && !sck_q;
    assign fall     = !cs_n && !sck && sck_q;
    assign rx_valid = rise && (bit_cnt == 3'd7);
    assign rx_byte  = {rx_sh[6:0], mosi};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            miso    <= 1'b0;
        end else begin
            sck_q <= sck;
            if (cs_n) begin
                bit_cnt <= '0;
                miso    <= 1'b0;
            end else begin
                if (rise) begin
                    rx_sh   <= rx_byte;
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (fall) begin
                    if (bit_cnt == 3'd0) begin
                        miso  <= tx_byte[7];
                        tx_sh <= {tx_byte[6:0], 1'b0};
                    end else begin
                        miso  <= tx_sh[7];
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sfe_byte_store.sv
module sfe_byte_store
    import sfe_pkg::*;
#(
    parameter int SMALL_AW = 4,
    parameter int BIG_AW   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             er_start,
    input  logic             er_big,
    input  logic [IDX_W-1:0] er_idx,
    output logic             er_busy,
    output logic             er_done
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] SMALL_MASK = IDX_W'((1 << SMALL_AW) - 1);
    localparam logic [IDX_W-1:0] BIG_MASK   = IDX_W'((1 << BIG_AW) - 1);

    logic [7:0]        mem [DEPTH];
    logic [IDX_W-1:0]  er_ptr;
    logic [WIN_AW-1:0] er_left;
    logic [IDX_W-1:0]  sel_mask;

    assign rd_data  = mem[rd_idx];
    assign sel_mask = er_big ? BIG_MASK : SMALL_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            er_busy <= 1'b0;
            er_done <= 1'b0;
            er_ptr  <= '0;
            er_left <= '0;
        end else begin
            er_done <= 1'b0;
            if (er_busy) begin
                mem[er_ptr] <= 8'hFF;
                er_ptr      <= er_ptr + 1'b1;
                er_left     <= er_left - 1'b1;
                if (er_left == '0) begin
                    er_busy <= 1'b0;
                    er_done <= 1'b1;
                end
            end else begin
                if (er_start) begin
                    er_busy <= 1'b1;
                    er_ptr  <= er_idx & ~sel_mask;
                    er_left <= sel_mask[WIN_AW-1:0];
                end
                if (wr_en) mem[wr_idx] <= mem[wr_idx] & wr_data;
            end
        end
    end
endmodule

// File: rtl/sfe_flash_engine.sv
module sfe_flash_engine
    import sfe_pkg::*;
#(
    parameter int SMALL_AW = 4,
    parameter int BIG_AW   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] fast_dummy,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso
);
    eng_state_t       state_q, state_d;
    cmd_kind_t        kind_q, kind_d;
    logic             fast_q, fast_d;
    logic             big_q, big_d;
    logic [3:0]       left_q, left_d;
    logic [SEG_W-1:0] seg_q, seg_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             wel_q, wel_d;
    logic             four_q, four_d;
    logic [7:0]       ear_q, ear_d;
    logic             armed_q, armed_d;
    logic [7:0]       tx_q, tx_d;

    logic             rx_valid;
    logic [7:0]       rx_byte;
    logic [IDX_W-1:0] rd_idx, wr_idx, fin_idx;
    logic [7:0]       rd_data;
    logic             wr_en, er_start, er_busy, er_done;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return {p[IDX_W-1:WIN_AW], p[WIN_AW-1:0] + 1'b1};
    endfunction

    sfe_bit_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .tx_byte(tx_q), .rx_valid(rx_valid), .rx_byte(rx_byte), .miso(miso)
    );

    sfe_byte_store #(.SMALL_AW(SMALL_AW), .BIG_AW(BIG_AW)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(rx_byte),
        .er_start(er_start), .er_big(big_q), .er_idx(fin_idx),
        .er_busy(er_busy), .er_done(er_done)
    );

    assign fin_idx = {seg_q, rx_byte};
    assign wr_idx  = ptr_q;

    always_comb begin
        state_d  = state_q;
        kind_d   = kind_q;
        fast_d   = fast_q;
        big_d    = big_q;
        left_d   = left_q;
        seg_d    = seg_q;
        ptr_d    = ptr_q;
        wel_d    = wel_q;
        four_d   = four_q;
        ear_d    = ear_q;
        armed_d  = armed_q;
        tx_d     = tx_q;
        rd_idx   = ptr_q;
        wr_en    = 1'b0;
        er_start = 1'b0;

        if (er_done) wel_d = 1'b0;

        if (cs_n) begin
            state_d = S_IDLE;
            tx_d    = '0;
            if (state_q == S_PROG) wel_d = 1'b0;
        end else if (rx_valid) begin
            unique case (state_q)
                S_IDLE: begin
                    tx_d    = '0;
                    armed_d = (rx_byte == OP_ARM);
                    state_d = S_SINK;
                    seg_d   = ear_q[SEG_W-1:0];
                    case (rx_byte)
                        OP_WEN:   wel_d  = 1'b1;
                        OP_M4ON:  four_d = 1'b1;
                        OP_M4OFF: four_d = 1'b0;
                        OP_FLAG: begin
                            tx_d    = {1'b1, 6'b0, four_q};
                            state_d = S_RESP;
                        end
                        OP_XRD: begin
                            tx_d    = ear_q;
                            state_d = S_RESP;
                        end
                        OP_XWR: if (wel_q) state_d = S_XWR;
                        OP_RST: begin
                            if (armed_q) begin
                                wel_d  = 1'b0;
                                four_d = 1'b0;
                                ear_d  = '0;
                            end
                        end
                        OP_RD3, OP_RD4, OP_FR3, OP_FR4, OP_PP3, OP_PP4,
                        OP_ES3, OP_ES4, OP_EB3, OP_EB4: begin
                            state_d = S_ADDR;
                            kind_d  = op_kind(rx_byte);
                            fast_d  = op_fast(rx_byte);
                            big_d   = op_big(rx_byte);
                            left_d  = (op_wide(rx_byte) || four_q) ? 4'd4 : 4'd3;
                        end
                        default: ;
                    endcase
                end
                S_ADDR: begin
                    left_d = left_q - 4'd1;
                    if (left_q == 4'd4) seg_d = rx_byte[SEG_W-1:0];
                    if (left_q == 4'd1) begin
                        ptr_d   = fin_idx;
                        state_d = S_SINK;
                        case (kind_q)
                            K_READ: begin
                                if (fast_q && (fast_dummy != 4'd0)) begin
                                    state_d = S_DUMMY;
                                    left_d  = fast_dummy;
                                end else begin
                                    state_d = S_READ;
                                    rd_idx  = fin_idx;
                                    tx_d    = rd_data;
                                    ptr_d   = step(fin_idx);
                                end
                            end
                            K_PROG:  if (wel_q) state_d = S_PROG;
                            K_ERASE: if (wel_q) er_start = 1'b1;
                            default: ;
                        endcase
                    end
                end
                S_DUMMY: begin
                    left_d = left_q - 4'd1;
                    if (left_q == 4'd1) begin
                        state_d = S_READ;
                        tx_d    = rd_data;
                        ptr_d   = step(ptr_q);
                    end
                end
                S_READ: begin
                    tx_d  = rd_data;
                    ptr_d = step(ptr_q);
                end
                S_PROG: begin
                    wr_en = !er_busy;
                    ptr_d = step(ptr_q);
                end
                S_XWR: begin
                    ear_d   = rx_byte;
                    state_d = S_SINK;
                end
                S_RESP: tx_d = '0;
                S_SINK: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= K_READ;
            fast_q  <= 1'b0;
            big_q   <= 1'b0;
            left_q  <= '0;
            seg_q   <= '0;
            ptr_q   <= '0;
            wel_q   <= 1'b0;
            four_q  <= 1'b0;
            ear_q   <= '0;
            armed_q <= 1'b0;
            tx_q    <= '0;
        end else begin
            kind_q  <= kind_d;
            fast_q  <= fast_d;
            big_q   <= big_d;
            left_q  <= left_d;
            seg_q   <= seg_d;
            ptr_q   <= ptr_d;
            wel_q   <= wel_d;
            four_q  <= four_d;
            ear_q   <= ear_d;
            armed_q <= armed_d;
            tx_q    <= tx_d;
        end
    end
endmodule

// File: rtl/sfe_flash_checker.sv
module sfe_flash_checker
    import sfe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       miso,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input eng_state_t state_q,
    input logic       armed_q,
    input logic       wel_q,
    input logic       four_q,
    input logic [7:0] ear_q,
    input logic       er_done
);
    logic op_seen;
    assign op_seen = !cs_n && rx_valid && (state_q == S_IDLE);

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (miso == 1'b0));

    p_mode_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_seen && rx_byte == OP_M4ON) |=> four_q);

    p_mode_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_seen && rx_byte == OP_M4OFF) |=> !four_q);

    p_seg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_seen && rx_byte == OP_XWR && !wel_q) |=> ($stable(ear_q) && state_q != S_XWR));

    p_prog_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && state_q == S_PROG) |=> !wel_q);

    p_erase_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (er_done && !(op_seen && rx_byte == OP_WEN)) |=> !wel_q);

    p_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_seen && rx_byte == OP_RST && armed_q) |=>
            (ear_q == 8'h00 && !four_q && !wel_q && !armed_q));

    p_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_seen && rx_byte != OP_ARM) |=> !armed_q);
endmodule

bind sfe_flash_engine sfe_flash_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .state_q(state_q),
    .armed_q(armed_q), .wel_q(wel_q), .four_q(four_q), .ear_q(ear_q),
    .er_done(er_done)
);

// File: tb/sim_sfe_flash_engine.sv
module sim_sfe_flash_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fast_dummy = 4'd0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rbuf [4];

    always #5 clk = ~clk;

    sfe_flash_engine u0 (
        .clk(clk), .rst_n(rst_n), .fast_dummy(fast_dummy),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    // {program opcode, read opcode, address, data}
    localparam logic [55:0] VEC [6] = '{
        {8'h02, 8'h03, 32'h0000_0005, 8'h3C},
        {8'h02, 8'h03, 32'h0000_007F, 8'h81},
        {8'h12, 8'h13, 32'h0100_0010, 8'hA5},
        {8'h12, 8'h13, 32'h0200_0033, 8'h5A},
        {8'h12, 8'h13, 32'h0300_0044, 8'h99},
        {8'h02, 8'h0B, 32'h0000_0050, 8'h11}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    function automatic int alen(input logic [7:0] op);
        return (op == 8'h13 || op == 8'h0C || op == 8'h12 ||
                op == 8'h21 || op == 8'hDC) ? 4 : 3;
    endfunction

    task automatic xb(input logic [7:0] o, output logic [7:0] i);
        for (int b = 7; b >= 0; b--) begin
            mosi = o[b];
            repeat (4) @(negedge clk);
            i[b] = miso;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_addr(input logic [31:0] a, input int n);
        logic [7:0] junk;
        for (int k = n - 1; k >= 0; k--) xb(a[8*k +: 8], junk);
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] junk;
        cs_lo();
        xb(op, junk);
        cs_hi();
    endtask

    task automatic reg_rd(input logic [7:0] op, output logic [7:0] v);
        logic [7:0] junk;
        cs_lo();
        xb(op, junk);
        xb(8'h00, v);
        cs_hi();
    endtask

    task automatic rdn(input logic [7:0] op, input logic [31:0] a, input int na,
                       input int nd, input int n);
        logic [7:0] junk;
        cs_lo();
        xb(op, junk);
        send_addr(a, na);
        for (int k = 0; k < nd; k++) xb(8'h00, junk);
        for (int k = 0; k < n; k++) xb(8'h00, rbuf[k]);
        cs_hi();
    endtask

    task automatic pp(input logic [7:0] op, input logic [31:0] a, input int na,
                      input logic [7:0] d);
        logic [7:0] junk;
        cs_lo();
        xb(op, junk);
        send_addr(a, na);
        xb(d, junk);
        cs_hi();
    endtask

    task automatic er(input logic [7:0] op, input logic [31:0] a, input int na);
        cs_lo();
        xb(op, rbuf[3]);
        send_addr(a, na);
        cs_hi();
        repeat (100) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        chk("R1 miso idle after reset", {7'b0, miso}, 8'h00);
        reg_rd(8'h70, v); chk("R1 R4 flag byte after reset", v, 8'h80);
        reg_rd(8'hC8, v); chk("R1 R6 segment reg after reset", v, 8'h00);

        // R8: program without write enable changes nothing
        pp(8'h02, 32'h60, 3, 8'h00);
        rdn(8'h03, 32'h60, 3, 0, 1); chk("R8 program refused", rbuf[0], 8'hFF);

        // table: program then read back (R2 R3 R8 R7)
        foreach (VEC[i]) begin
            op1(8'h06);
            pp(VEC[i][55:48], VEC[i][39:8], alen(VEC[i][55:48]), VEC[i][7:0]);
            rdn(VEC[i][47:40], VEC[i][39:8], alen(VEC[i][47:40]), 0, 1);
            chk($sformatf("R2 R3 R8 vector %0d", i), rbuf[0], VEC[i][7:0]);
        end

        // R2 sequential read and wrap inside the window
        op1(8'h06); pp(8'h02, 32'h0, 3, 8'h42);
        rdn(8'h03, 32'h7F, 3, 0, 2);
        chk("R2 read at offset 7F", rbuf[0], 8'h81);
        chk("R2 next byte 80 untouched", rbuf[1], 8'hFF);
        rdn(8'h03, 32'hFF, 3, 0, 2);
        chk("R2 wrap byte FF", rbuf[0], 8'hFF);
        chk("R2 wrap to offset 00", rbuf[1], 8'h42);

        // R8 AND, R10 enable dropped after program
        op1(8'h06); pp(8'h02, 32'h05, 3, 8'hF0);
        rdn(8'h03, 32'h05, 3, 0, 1); chk("R8 program ANDs", rbuf[0], 8'h30);
        pp(8'h02, 32'h05, 3, 8'h00);
        rdn(8'h03, 32'h05, 3, 0, 1); chk("R10 enable dropped after program", rbuf[0], 8'h30);

        // R3 R4 address mode
        op1(8'hB7);
        reg_rd(8'h70, v); chk("R4 flag in 4-byte mode", v, 8'h81);
        rdn(8'h03, 32'h0100_0010, 4, 0, 1); chk("R3 plain read takes 4 bytes", rbuf[0], 8'hA5);
        op1(8'hE9);
        reg_rd(8'h70, v); chk("R4 flag after leaving mode", v, 8'h80);

        // R6 R5 segment register
        cs_lo(); xb(8'hC5, v); xb(8'h02, v); cs_hi();
        reg_rd(8'hC8, v); chk("R6 write refused without enable", v, 8'h00);
        op1(8'h06);
        cs_lo(); xb(8'hC5, v); xb(8'h02, v); cs_hi();
        reg_rd(8'hC8, v); chk("R6 segment register written", v, 8'h02);
        rdn(8'h03, 32'h33, 3, 0, 1); chk("R5 3-byte address in segment 2", rbuf[0], 8'h5A);
        rdn(8'h03, 32'h05, 3, 0, 1); chk("R5 segment 0 not used", rbuf[0], 8'hFF);

        // R7 dummy bytes
        fast_dummy = 4'd2;
        rdn(8'h0C, 32'h50, 4, 2, 2);
        chk("R7 data after two dummies", rbuf[0], 8'h11);
        chk("R7 following byte", rbuf[1], 8'hFF);
        fast_dummy = 4'd0;
        rdn(8'h0C, 32'h50, 4, 0, 1); chk("R7 zero dummies", rbuf[0], 8'h11);

        // R9 erase
        op1(8'h06); pp(8'h12, 32'h0200_0040, 4, 8'h77);
        op1(8'h06); er(8'h20, 32'h35, 3);
        rdn(8'h13, 32'h0200_0033, 4, 0, 1); chk("R9 small erase clears", rbuf[0], 8'hFF);
        rdn(8'h13, 32'h0200_0040, 4, 0, 1); chk("R9 outside small block kept", rbuf[0], 8'h77);
        op1(8'h06); er(8'hDC, 32'h0200_0041, 4);
        rdn(8'h13, 32'h0200_0040, 4, 0, 1); chk("R9 sector erase clears", rbuf[0], 8'hFF);
        er(8'hDC, 32'h0100_0000, 4);
        rdn(8'h13, 32'h0100_0010, 4, 0, 1); chk("R10 enable dropped after erase", rbuf[0], 8'hA5);
        op1(8'h06); pp(8'h12, 32'h0200_0010, 4, 8'h66);
        op1(8'h06); er(8'hD8, 32'h0, 3);
        rdn(8'h13, 32'h0200_0010, 4, 0, 1); chk("R9 R5 sector erase in segment", rbuf[0], 8'hFF);
        rdn(8'h13, 32'h0000_0005, 4, 0, 1); chk("R9 other segment kept", rbuf[0], 8'h30);

        // R11 reset sequence
        op1(8'hB7);
        op1(8'h66); op1(8'h06); op1(8'h99);
        reg_rd(8'h70, v); chk("R11 disarmed reset ignored, mode", v, 8'h81);
        reg_rd(8'hC8, v); chk("R11 disarmed reset ignored, segment", v, 8'h02);
        op1(8'h66); op1(8'h99);
        reg_rd(8'h70, v); chk("R11 reset clears mode", v, 8'h80);
        reg_rd(8'hC8, v); chk("R11 reset clears segment", v, 8'h00);
        cs_lo(); xb(8'hC5, v); xb(8'h01, v); cs_hi();
        reg_rd(8'hC8, v); chk("R11 reset clears write enable", v, 8'h00);

        // R12 abort mid-address
        cs_lo(); xb(8'h03, v); xb(8'h00, v); cs_hi();
        reg_rd(8'h70, v); chk("R12 fresh opcode after abort", v, 8'h80);
        chk("R1 miso idle while deselected", {7'b0, miso}, 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule